// File: doc/BRIEF.md
# DMA External Request Command Interface

This block sits between an external device and a four-channel DMA controller. The device raises a bus request. The block answers with a one-clock bus-available strobe. The device then presents a 7-bit command word. The block decodes that word into one of four actions:

- a data-bus handshake transfer on channel 0;
- a transfer-end request that drops the channel 0 enable;
- a clear of every pending request, which also releases the controller's freeze state;
- a queued transfer request to channel 1, 2 or 3.

The block holds a pending flag for channel 0, a small counting queue for each of channels 1 to 3, the channel 0 enable bit and the freeze flag. The DMA engine takes pending requests through per-channel pop strobes. Software can rewrite the channel 0 enable to restart that channel after a transfer end.

The bus-available output is shared with the memory controller. When a row miss forces a precharge, the output is held high for a programmable number of clocks. A bus request recognised in that window is discarded and gets no strobe of its own.

Top module: `dma_xreq_cmd`

## Requirements
- R1: A command with ID=00, MD=00 and SZ neither 101 nor 110 gives a one-clock pulse on `ch0_hs_o` in the cycle after the command. It also sets `ch0_req_o`, which stays high until `ch_pop_i[0]`. Command layout: bit 6..5 ID, bit 4..3 MD, bit 2..0 SZ.
- R2: A command with ID=00, MD≠00 and SZ=111 clears `ch0_en_o` in the next cycle, provided `ch0_burst_edge_i` is low.
- R3: While `ch0_burst_edge_i` is high, a transfer-end command leaves `ch0_en_o` unchanged.
- R4: A command with ID=00, MD=10 and SZ=110 does the following in the next cycle: clears `ch0_req_o`, sets all queue counts to zero, clears `freeze_o`, and drops any bus request already recognised so that no strobe follows it. `freeze_set_i` sets `freeze_o`.
- R5: A command with ID≠00 adds one request to the queue of channel ID. Its MD and SZ fields have no effect.
- R6: Each queue holds at most QDEPTH requests (default 4). A push into a full queue is discarded and sets that queue's bit of `q_ovf_o`. The bit stays set through later commands, including the clear command. `q_ovf_o` bit 0 belongs to channel 1.
- R7: A bus request driven in cycle t is recognised at the following edge. `bus_avail_o` is then high for exactly the one cycle after the next edge, which is two edges after the request.
- R8: `row_miss_i` loads `prech_cyc_i`. `bus_avail_o` then stays high for that many cycles starting after the next edge. A bus request recognised while the window is open gets no strobe.
- R9: A bus request that arrives while an earlier one is recognised but not yet answered sets the sticky `proto_err_o` and raises no second strobe.
- R10: A register write (`ch0_en_we_i`) loads `ch0_en_o` from `ch0_en_wd_i` in the next cycle. This restarts channel 0 after a transfer end.
- R11: Command codes that match none of the four actions change no output. Examples: ID=00 with MD=00 and SZ=101; MD=01 with SZ=110; MD≠00 with SZ other than 110 or 111.
- R12: `ch_pop_i[c]` removes one request from queue c. A pop on an empty queue has no effect. A push and a pop together on a full queue leave its count unchanged and set no overflow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_req_i | input | 1 | Bus request from the external device |
| row_miss_i | input | 1 | Row miss: start a precharge hold window |
| prech_cyc_i | input | PCW | Length of the precharge window in clocks |
| bus_avail_o | output | 1 | Bus-available strobe or precharge hold |
| proto_err_o | output | 1 | Sticky flag for a repeated bus request |
| cmd_vld_i | input | 1 | Command word valid |
| cmd_i | input | 7 | Command word: ID[6:5], MD[4:3], SZ[2:0] |
| ch0_burst_edge_i | input | 1 | Channel 0 is running an edge-triggered burst |
| ch0_en_we_i | input | 1 | Write strobe for the channel 0 enable |
| ch0_en_wd_i | input | 1 | Write data for the channel 0 enable |
| freeze_set_i | input | 1 | Controller enters the freeze state |
| ch_pop_i | input | NCH | Per-channel request taken by the DMA engine |
| ch0_hs_o | output | 1 | Channel 0 handshake pulse |
| ch0_req_o | output | 1 | Channel 0 request pending |
| ch0_en_o | output | 1 | Channel 0 enable |
| q_cnt_o | output | (NCH-1)*CNTW | Queue counts, channel 1 in the low bits |
| q_ovf_o | output | NCH-1 | Sticky overflow per queue |
| freeze_o | output | 1 | Freeze state |

## Verification
The bench builds the block with NCH=4, QDEPTH=4 and PCW=4. A queue depth of four lets five pushes to one channel reach the overflow boundary, as well as the combined push-and-pop case on a full queue. A 4-bit precharge width covers windows of zero, one and three clocks, so a bus request can be placed inside a window and a zero-length window shows no hold at all.

// File: rtl/dxr_pkg.sv
package dxr_pkg;
  localparam int unsigned ID_W  = 2;
  localparam int unsigned MD_W  = 2;
  localparam int unsigned SZ_W  = 3;
  localparam int unsigned CMD_W = ID_W + MD_W + SZ_W;

  typedef struct packed {
    logic [ID_W-1:0] id;
    logic [MD_W-1:0] md;
    logic [SZ_W-1:0] sz;
  } cmd_t;

  typedef enum logic [2:0] {
    ACT_NONE = 3'd0,
    ACT_HS0  = 3'd1,
    ACT_END0 = 3'd2,
    ACT_CLR  = 3'd3,
    ACT_QREQ = 3'd4
  } act_e;
endpackage

// File: rtl/dxr_decode.sv
module dxr_decode
  import dxr_pkg::*;
(
  input  logic            vld_i,
  input  cmd_t            cmd_i,
  output act_e            act_o,
  output logic [ID_W-1:0] chan_o
);
  always_comb begin
    act_o  = ACT_NONE;
    chan_o = cmd_i.id;
    if (vld_i) begin
      if (cmd_i.id != '0)
        act_o = ACT_QREQ;
      else if (cmd_i.md == 2'b10 && cmd_i.sz == 3'b110)
        act_o = ACT_CLR;
      else if (cmd_i.md != 2'b00 && cmd_i.sz == 3'b111)
        act_o = ACT_END0;
      else if (cmd_i.md == 2'b00 && cmd_i.sz != 3'b101 && cmd_i.sz != 3'b110)
        act_o = ACT_HS0;
    end
  end
endmodule

// File: rtl/dxr_bus_arb.sv
module dxr_bus_arb #(
  parameter int unsigned PCW = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           bus_req_i,
  input  logic           row_miss_i,
  input  logic [PCW-1:0] prech_i,
  input  logic           clr_i,
  output logic           strobe_o,
  output logic           bus_avail_o,
  output logic           proto_err_o
);
  logic           req_q, req_d;
  logic           ba_q, ba_d;
  logic           err_q, err_d;
  logic [PCW-1:0] pc_q, pc_d;
  logic           pc_busy;

  assign pc_busy = (pc_q != '0);

  always_comb begin
    req_d = req_q;
    ba_d  = 1'b0;
    err_d = err_q;
    pc_d  = pc_q;
    if (pc_busy) pc_d = pc_q - 1'b1;
    if (row_miss_i) pc_d = prech_i;
    if (req_q) begin
      req_d = 1'b0;
      if (!pc_busy) ba_d = 1'b1;
    end
    if (bus_req_i) begin
      if (req_q) err_d = 1'b1;
      else       req_d = 1'b1;
    end
    if (clr_i) begin
      req_d = 1'b0;
      ba_d  = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q <= 1'b0;
      ba_q  <= 1'b0;
      err_q <= 1'b0;
      pc_q  <= '0;
    end else begin
      req_q <= req_d;
      ba_q  <= ba_d;
      err_q <= err_d;
      pc_q  <= pc_d;
    end
  end

  assign strobe_o    = ba_q;
  assign bus_avail_o = ba_q | pc_busy;
  assign proto_err_o = err_q;
endmodule

// File: rtl/dxr_chan_q.sv
module dxr_chan_q #(
  parameter int unsigned DEPTH = 4,
  parameter int unsigned CW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push_i,
  input  logic          pop_i,
  input  logic          clr_i,
  output logic [CW-1:0] cnt_o,
  output logic          ovf_o
);
  logic [CW-1:0] cnt_q, cnt_d;
  logic          ovf_q, ovf_d;
  logic          full, empty;

  assign full  = (cnt_q == CW'(DEPTH));
  assign empty = (cnt_q == '0);

  always_comb begin
    cnt_d = cnt_q;
    ovf_d = ovf_q;
    if (clr_i) begin
      cnt_d = '0;
    end else begin
      case ({push_i, pop_i})
        2'b10: begin
          if (full) ovf_d = 1'b1;
          else      cnt_d = cnt_q + 1'b1;
        end
        2'b01: if (!empty) cnt_d = cnt_q - 1'b1;
        2'b11: if (empty)  cnt_d = cnt_q + 1'b1;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      ovf_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      ovf_q <= ovf_d;
    end
  end

  assign cnt_o = cnt_q;
  assign ovf_o = ovf_q;
endmodule

// File: rtl/dma_xreq_cmd.sv
module dma_xreq_cmd
  import dxr_pkg::*;
#(
  parameter int unsigned NCH    = 4,
  parameter int unsigned QDEPTH = 4,
  parameter int unsigned PCW    = 4,
  localparam int unsigned NQ    = NCH - 1,
  localparam int unsigned CNTW  = $clog2(QDEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_req_i,
  input  logic              row_miss_i,
  input  logic [PCW-1:0]    prech_cyc_i,
  output logic              bus_avail_o,
  output logic              proto_err_o,
  input  logic              cmd_vld_i,
  input  logic [CMD_W-1:0]  cmd_i,
  input  logic              ch0_burst_edge_i,
  input  logic              ch0_en_we_i,
  input  logic              ch0_en_wd_i,
  input  logic              freeze_set_i,
  input  logic [NCH-1:0]    ch_pop_i,
  output logic              ch0_hs_o,
  output logic              ch0_req_o,
  output logic              ch0_en_o,
  output logic [NQ*CNTW-1:0] q_cnt_o,
  output logic [NQ-1:0]     q_ovf_o,
  output logic              freeze_o
);
  act_e            act;
  logic [ID_W-1:0] chan;
  logic            clr_all;
  logic            req_strobe;

  dxr_decode u_dec (
    .vld_i  (cmd_vld_i),
    .cmd_i  (cmd_t'(cmd_i)),
    .act_o  (act),
    .chan_o (chan)
  );

  assign clr_all = (act == ACT_CLR);

  dxr_bus_arb #(.PCW(PCW)) u_arb (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_req_i   (bus_req_i),
    .row_miss_i  (row_miss_i),
    .prech_i     (prech_cyc_i),
    .clr_i       (clr_all),
    .strobe_o    (req_strobe),
    .bus_avail_o (bus_avail_o),
    .proto_err_o (proto_err_o)
  );

  for (genvar c = 1; c < NCH; c++) begin : g_q
    logic push;
    assign push = (act == ACT_QREQ) && (chan == ID_W'(c));
    dxr_chan_q #(.DEPTH(QDEPTH), .CW(CNTW)) u_q (
      .clk    (clk),
      .rst_n  (rst_n),
      .push_i (push),
      .pop_i  (ch_pop_i[c]),
      .clr_i  (clr_all),
      .cnt_o  (q_cnt_o[(c-1)*CNTW +: CNTW]),
      .ovf_o  (q_ovf_o[c-1])
    );
  end

  logic en_q, en_d, hs_q, hs_d, req0_q, req0_d, frz_q, frz_d;

  always_comb begin
    en_d = en_q;
    if (act == ACT_END0 && !ch0_burst_edge_i) en_d = 1'b0;
    if (ch0_en_we_i) en_d = ch0_en_wd_i;
    hs_d   = (act == ACT_HS0);
    req0_d = req0_q;
    if (ch_pop_i[0]) req0_d = 1'b0;
    if (act == ACT_HS0) req0_d = 1'b1;
    if (clr_all) req0_d = 1'b0;
    frz_d = frz_q;
    if (freeze_set_i) frz_d = 1'b1;
    if (clr_all) frz_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      hs_q   <= 1'b0;
      req0_q <= 1'b0;
      frz_q  <= 1'b0;
    end else begin
      en_q   <= en_d;
      hs_q   <= hs_d;
      req0_q <= req0_d;
      frz_q  <= frz_d;
    end
  end

  assign ch0_en_o  = en_q;
  assign ch0_hs_o  = hs_q;
  assign ch0_req_o = req0_q;
  assign freeze_o  = frz_q;
endmodule

// File: rtl/dxr_chk.sv
module dxr_chk
  import dxr_pkg::*;
#(
  parameter int unsigned NQ     = 3,
  parameter int unsigned CNTW   = 3,
  parameter int unsigned QDEPTH = 4
) (
  input logic              clk,
  input logic              rst_n,
  input act_e              act,
  input logic              ch0_burst_edge_i,
  input logic              ch0_en_we_i,
  input logic              ch0_en_o,
  input logic              ch0_hs_o,
  input logic              ch0_req_o,
  input logic [NQ*CNTW-1:0] q_cnt_o,
  input logic [NQ-1:0]     q_ovf_o,
  input logic              freeze_o,
  input logic              proto_err_o,
  input logic              req_strobe
);
  a_r1_hs_sets_pending: assert property (@(posedge clk) disable iff (!rst_n)
    ch0_hs_o |-> ch0_req_o);

  a_r2_end_drops_enable: assert property (@(posedge clk) disable iff (!rst_n)
    (act == ACT_END0 && !ch0_burst_edge_i && !ch0_en_we_i) |=> !ch0_en_o);

  a_r3_burst_keeps_enable: assert property (@(posedge clk) disable iff (!rst_n)
    (act == ACT_END0 && ch0_burst_edge_i && !ch0_en_we_i) |=> $stable(ch0_en_o));

  a_r4_clear_empties: assert property (@(posedge clk) disable iff (!rst_n)
    (act == ACT_CLR) |=> (q_cnt_o == '0 && !ch0_req_o && !freeze_o));

  a_r6_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((q_ovf_o & $past(q_ovf_o)) == $past(q_ovf_o)));

  for (genvar i = 0; i < NQ; i++) begin : g_bound
    a_r6_depth_bound: assert property (@(posedge clk) disable iff (!rst_n)
      q_cnt_o[i*CNTW +: CNTW] <= CNTW'(QDEPTH));
  end

  a_r7_strobe_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    req_strobe |=> !req_strobe);

  a_r9_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    proto_err_o |=> proto_err_o);
endmodule

bind dma_xreq_cmd dxr_chk #(.NQ(NQ), .CNTW(CNTW), .QDEPTH(QDEPTH)) u_chk (
  .clk              (clk),
  .rst_n            (rst_n),
  .act              (act),
  .ch0_burst_edge_i (ch0_burst_edge_i),
  .ch0_en_we_i      (ch0_en_we_i),
  .ch0_en_o         (ch0_en_o),
  .ch0_hs_o         (ch0_hs_o),
  .ch0_req_o        (ch0_req_o),
  .q_cnt_o          (q_cnt_o),
  .q_ovf_o          (q_ovf_o),
  .freeze_o         (freeze_o),
  .proto_err_o      (proto_err_o),
  .req_strobe       (req_strobe)
);

// File: tb/test_dma_xreq_cmd.sv
`timescale 1ns/1ps
module test_dma_xreq_cmd;
  localparam int NCH = 4, QDEPTH = 4, PCW = 4, CNTW = 3, NQ = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_req = 1'b0, row_miss = 1'b0;
  logic [PCW-1:0] prech = '0;
  logic bus_avail, proto_err;
  logic cmd_vld = 1'b0;
  logic [6:0] cmd = '0;
  logic burst = 1'b0, we = 1'b0, wd = 1'b0, frz_set = 1'b0;
  logic [NCH-1:0] pop = '0;
  logic hs, req0, en, frz;
  logic [NQ*CNTW-1:0] qcnt;
  logic [NQ-1:0] ovf;

  always #5 clk = ~clk;

  dma_xreq_cmd #(.NCH(NCH), .QDEPTH(QDEPTH), .PCW(PCW)) i_dma_xreq_cmd (
    .clk(clk), .rst_n(rst_n), .bus_req_i(bus_req), .row_miss_i(row_miss),
    .prech_cyc_i(prech), .bus_avail_o(bus_avail), .proto_err_o(proto_err),
    .cmd_vld_i(cmd_vld), .cmd_i(cmd), .ch0_burst_edge_i(burst),
    .ch0_en_we_i(we), .ch0_en_wd_i(wd), .freeze_set_i(frz_set),
    .ch_pop_i(pop), .ch0_hs_o(hs), .ch0_req_o(req0), .ch0_en_o(en),
    .q_cnt_o(qcnt), .q_ovf_o(ovf), .freeze_o(frz)
  );

  typedef struct {
    int          cyc;
    int          sel;
    int unsigned val;
    string       tag;
  } exp_t;

  exp_t exp_q[$];
  int cyc = 0;
  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  function automatic int unsigned obs(int s);
    case (s)
      0: return 32'(bus_avail);
      1: return 32'(hs);
      2: return 32'(req0);
      3: return 32'(en);
      4: return 32'(qcnt[0 +: CNTW]);
      5: return 32'(qcnt[CNTW +: CNTW]);
      6: return 32'(qcnt[2*CNTW +: CNTW]);
      7: return 32'(ovf);
      8: return 32'(frz);
      default: return 32'(proto_err);
    endcase
  endfunction

  function automatic void expect_at(int d, int s, int unsigned v, string tag);
    exp_t e;
    int i;
    e.cyc = cyc + d; e.sel = s; e.val = v; e.tag = tag;
    i = exp_q.size();
    while (i > 0 && exp_q[i-1].cyc > e.cyc) i--;
    exp_q.insert(i, e);
  endfunction

  // monitor: pops expected items when their cycle arrives
  always @(posedge clk) begin : mon
    exp_t e;
    #1;
    cyc++;
    while (exp_q.size() != 0 && exp_q[0].cyc <= cyc) begin
      e = exp_q.pop_front();
      n_chk++;
      if (obs(e.sel) !== e.val) begin
        n_fail++;
        $display("FAIL %s: cycle %0d output %0d actual %0d expected %0d",
                 e.tag, cyc, e.sel, obs(e.sel), e.val);
      end
    end
  end

  task automatic idle();
    @(negedge clk);
    cmd_vld = 1'b0; bus_req = 1'b0; row_miss = 1'b0;
    we = 1'b0; frz_set = 1'b0; pop = '0;
  endtask

  task automatic set_cmd(logic [1:0] id, logic [1:0] md, logic [2:0] sz);
    cmd_vld = 1'b1;
    cmd = {id, md, sz};
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    idle();
    for (int s = 0; s < 10; s++) expect_at(1, s, 0, "reset");

    // R10: enable write
    idle(); we = 1'b1; wd = 1'b1; expect_at(1, 3, 1, "R10");
    // R1: handshake
    idle(); set_cmd(2'b00, 2'b00, 3'b000);
    expect_at(1, 1, 1, "R1"); expect_at(1, 2, 1, "R1"); expect_at(2, 1, 0, "R1");
    idle();
    idle(); pop = 4'b0001; expect_at(1, 2, 0, "R1");
    // R2: transfer end, then R10 restart
    idle(); set_cmd(2'b00, 2'b01, 3'b111); expect_at(1, 3, 0, "R2");
    idle();
    idle(); we = 1'b1; wd = 1'b1; expect_at(1, 3, 1, "R10");
    // R3: refused during edge burst
    idle(); burst = 1'b1; set_cmd(2'b00, 2'b11, 3'b111);
    expect_at(1, 3, 1, "R3"); expect_at(2, 3, 1, "R3");
    idle();
    idle(); burst = 1'b0;
    // R5: queued requests, other fields ignored
    idle(); set_cmd(2'b00, 2'b00, 3'b000);
    idle(); set_cmd(2'b01, 2'b10, 3'b110);
    expect_at(1, 4, 1, "R5"); expect_at(1, 2, 1, "R5");
    idle(); set_cmd(2'b10, 2'b00, 3'b000);
    expect_at(1, 5, 1, "R5"); expect_at(1, 1, 0, "R5");
    idle(); set_cmd(2'b11, 2'b01, 3'b111);
    expect_at(1, 6, 1, "R5"); expect_at(1, 3, 1, "R5");
    // R6: fill channel 3 queue and overflow
    for (int k = 2; k <= 4; k++) begin
      idle(); set_cmd(2'b11, 2'b00, 3'b000); expect_at(1, 6, k, "R6");
    end
    idle(); set_cmd(2'b11, 2'b00, 3'b000);
    expect_at(1, 6, 4, "R6"); expect_at(1, 7, 3'b100, "R6");
    idle(); expect_at(1, 7, 3'b100, "R6");
    // R12: pops
    idle(); pop = 4'b0010; expect_at(1, 4, 0, "R12");
    idle(); pop = 4'b0010; expect_at(1, 4, 0, "R12");
    idle(); pop = 4'b1000; set_cmd(2'b11, 2'b00, 3'b000);
    expect_at(1, 6, 4, "R12"); expect_at(1, 7, 3'b100, "R12");
    // R11: reserved codes
    idle(); set_cmd(2'b00, 2'b00, 3'b101);
    expect_at(1, 1, 0, "R11"); expect_at(1, 3, 1, "R11"); expect_at(1, 2, 1, "R11");
    idle(); set_cmd(2'b00, 2'b01, 3'b110);
    expect_at(1, 2, 1, "R11"); expect_at(1, 6, 4, "R11");
    idle(); set_cmd(2'b00, 2'b11, 3'b010);
    expect_at(1, 3, 1, "R11"); expect_at(1, 5, 1, "R11");
    // R4: freeze then clear, with a recognised bus request dropped
    idle(); frz_set = 1'b1; expect_at(1, 8, 1, "R4");
    idle(); bus_req = 1'b1;
    idle(); set_cmd(2'b00, 2'b10, 3'b110);
    expect_at(1, 2, 0, "R4"); expect_at(1, 4, 0, "R4"); expect_at(1, 5, 0, "R4");
    expect_at(1, 6, 0, "R4"); expect_at(1, 8, 0, "R4"); expect_at(1, 0, 0, "R4");
    expect_at(2, 0, 0, "R4"); expect_at(1, 7, 3'b100, "R6");
    idle(); idle();
    // R7: single strobe
    idle(); bus_req = 1'b1;
    expect_at(1, 0, 0, "R7"); expect_at(2, 0, 1, "R7"); expect_at(3, 0, 0, "R7");
    idle(); idle(); idle();
    // R9: back-to-back request
    idle(); bus_req = 1'b1;
    expect_at(1, 9, 0, "R9"); expect_at(2, 0, 1, "R9");
    expect_at(2, 9, 1, "R9"); expect_at(3, 0, 0, "R9");
    idle(); bus_req = 1'b1;
    idle(); idle(); idle();
    // R8: precharge windows
    idle(); row_miss = 1'b1; prech = 4'd3;
    expect_at(1, 0, 1, "R8"); expect_at(2, 0, 1, "R8"); expect_at(3, 0, 1, "R8");
    expect_at(4, 0, 0, "R8"); expect_at(5, 0, 0, "R8");
    idle(); bus_req = 1'b1;
    repeat (5) idle();
    idle(); row_miss = 1'b1; prech = 4'd1;
    expect_at(1, 0, 1, "R8"); expect_at(2, 0, 0, "R8");
    idle(); idle();
    idle(); row_miss = 1'b1; prech = 4'd0;
    expect_at(1, 0, 0, "R8");
    repeat (5) idle();
    wait (exp_q.size() == 0);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule